// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

The block is a watchdog counter that a slow tick enable from elsewhere on the chip advances. Software controls it through a single 32-bit control word. That word packs three fields: a reload count, a run/stop command bit and a 7-bit key. Once the stored word has its command bit set, the watchdog is armed. From then on a new write is taken only if its key is the bitwise inverse of the key held in the stored word. A program that has lost control and keeps writing the same value therefore cannot keep the watchdog alive.

Expiry is handled in two stages. When the countdown first reaches its end, the block raises a non-maskable interrupt level. It then reloads a short grace count and keeps counting. If the grace count also runs out before software refreshes the watchdog, the block issues a one-cycle system reset request and the countdown halts. A valid refresh drops the interrupt and returns the expiry stage to its initial state. Generating the slow tick and acting on the reset request are left to the surrounding logic.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `ctrl_o` reads 0 and `nmi_o` and `rst_req_o` are low. The countdown is stopped, so ticks produce no expiry until a write starts it.
- R2: While stored bit 8 is 0, every write is accepted, whatever its key field holds.
- R3: While stored bit 8 is 1, a write is accepted only when its bits [15:9] equal the 7-bit inverse of stored bits [15:9]. A rejected write leaves `ctrl_o`, the countdown and `nmi_o` unchanged.
- R4: An accepted write presented in cycle k appears on `ctrl_o` from cycle k+1.
- R5: An accepted write loads the countdown with data bits [8:0], and a value of 0 loads 256. Because bit 8 lies inside this field, a write that starts the countdown always loads 256 or more. The first expiry comes on exactly that many ticks after the load.
- R6: On an accepted write, bit 8 = 1 starts the countdown and bit 8 = 0 stops it. A stopped countdown ignores ticks.
- R7: On the first expiry, `nmi_o` goes high in the cycle after the expiring tick. The countdown then reloads GRACE_TICKS and keeps running.
- R8: When the grace count expires, `rst_req_o` is high for exactly one cycle and the countdown stops. `nmi_o` stays high.
- R9: An accepted write lowers `nmi_o` and returns the expiry stage to its first stage. The next expiry then raises the interrupt again and does not request a reset.
- R10: The countdown moves only on cycles with `tick_i` high. A write in the same cycle as a tick takes precedence, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow tick enable, one cycle per count step |
| wr_en_i | input | 1 | Control write strobe |
| wr_data_i | input | 32 | Control write value |
| ctrl_o | output | 32 | Stored control word |
| nmi_o | output | 1 | Non-maskable interrupt level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bound checker watches every cycle for four things. A rejected keyed write must leave the control word unchanged. An accepted write must be stored and must clear both the interrupt and the reset request. A reset request must be a single cycle and must always occur with the interrupt already raised. The interrupt may rise only after a tick. The exact tick counts cannot be checked per cycle: the 0-means-256 rule, a load of 256 or more whenever the countdown runs, and the grace length. The bench scenarios cover these, along with refresh during the grace window, the stop command and tick gating. They compare the cycle of each interrupt and reset event with a schedule computed beforehand.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W  = 32;
  localparam int KEY_W   = 7;
  localparam int CNT_W   = 9;
  localparam int CMD_BIT = 8;
  localparam int KEY_LSB = 9;
  localparam logic [CNT_W-1:0] ZERO_LOAD = CNT_W'(256);

  function automatic logic [CNT_W-1:0] reload_of(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = v[CNT_W-1:0];
    return (c == '0) ? ZERO_LOAD : c;
  endfunction
endpackage

// File: rtl/kwd_gate.sv
module kwd_gate
  import kwd_pkg::*;
(
  input  logic [DATA_W-1:0] stored_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              accept_o
);
  logic [KEY_W-1:0] key_need;
  logic             armed;

  assign armed    = stored_i[CMD_BIT];
  assign key_need = ~stored_i[KEY_LSB +: KEY_W];
  assign accept_o = wr_en_i & (~armed | (wr_data_i[KEY_LSB +: KEY_W] == key_need));
endmodule

// File: rtl/kwd_count.sv
module kwd_count
  import kwd_pkg::*;
#(
  parameter int GRACE_TICKS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             first_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = run_q & tick_i & ~load_i & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= run_i;
    end else if (expire_o) begin
      // first expiry: reload grace and keep going; second: halt
      if (first_i) cnt_q <= GRACE_V;
      else         run_q <= 1'b0;
    end else if (run_q && tick_i && cnt_q > CNT_W'(1)) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/kwd_stage.sv
module kwd_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic expire_i,
  output logic first_o,
  output logic nmi_o,
  output logic rst_req_o
);
  logic hit_q, nmi_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      nmi_q <= 1'b0;
      req_q <= 1'b0;
    end else if (clear_i) begin
      hit_q <= 1'b0;
      nmi_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= expire_i & hit_q;
      if (expire_i && !hit_q) begin
        hit_q <= 1'b1;
        nmi_q <= 1'b1;
      end
    end
  end

  assign first_o   = ~hit_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int GRACE_TICKS = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              nmi_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] ctrl_q;
  logic              accept, expire, first;

  kwd_gate u_gate (
    .stored_i (ctrl_q),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .accept_o (accept)
  );

  kwd_count #(.GRACE_TICKS(GRACE_TICKS)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .load_val_i(reload_of(wr_data_i)),
    .run_i     (wr_data_i[CMD_BIT]),
    .tick_i    (tick_i),
    .first_i   (first),
    .expire_o  (expire)
  );

  kwd_stage u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (accept),
    .expire_i (expire),
    .first_o  (first),
    .nmi_o    (nmi_o),
    .rst_req_o(rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_data_i;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [31:0] wr_data_i,
  input logic [31:0] ctrl_o,
  input logic        nmi_o,
  input logic        rst_req_o
);
  logic key_ok, take;
  assign key_ok = (wr_data_i[15:9] == ~ctrl_o[15:9]);
  assign take   = wr_en_i && (!ctrl_o[8] || key_ok);

  AST_LOCKED_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && ctrl_o[8] && !key_ok |=> $stable(ctrl_o)); // R3
  AST_WRITE_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> ctrl_o == $past(wr_data_i)); // R4
  AST_WRITE_CLEARS_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> !nmi_o && !rst_req_o); // R9
  AST_RST_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R8
  AST_RST_AFTER_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> nmi_o); // R8
  AST_NMI_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_o) |-> $past(tick_i)); // R10
  AST_STOPPED_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[8] |-> !rst_req_o); // R6
endmodule

bind keyed_watchdog kwd_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .ctrl_o   (ctrl_o),
  .nmi_o    (nmi_o),
  .rst_req_o(rst_req_o)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
  localparam int GRACE = 1;
  localparam int EV_NMI = 1;
  localparam int EV_RST = 2;

  typedef struct {
    int kind;
    int at;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl;
  logic        nmi, rst_req;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic nmi_prev = 1'b0;
  ev_t  exp_q[$];

  keyed_watchdog #(.GRACE_TICKS(GRACE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .nmi_o(nmi), .rst_req_o(rst_req)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk(input int key, input int cmd, input int low);
    return 32'((key & 7'h7f) << 9) | 32'((cmd & 1) << 8) | 32'(low & 8'hff);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push(input int kind, input int at);
    ev_t e;
    e.kind = kind;
    e.at   = at;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s actual=%0d pending expected=0 pending", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // monitor: pops scheduled events as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (nmi && !nmi_prev) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R7 actual=nmi@%0d expected=no event", cyc);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (e.kind != EV_NMI || e.at != cyc) begin
            bad++;
            $display("FAIL R7 actual=nmi@%0d expected=kind%0d@%0d", cyc, e.kind, e.at);
          end
        end
      end
      if (rst_req) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R8 actual=rst@%0d expected=no event", cyc);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          if (e.kind != EV_RST || e.at != cyc) begin
            bad++;
            $display("FAIL R8 actual=rst@%0d expected=kind%0d@%0d", cyc, e.kind, e.at);
          end
        end
      end
    end
    nmi_prev <= nmi;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
      finish_run();
    end
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, stopped countdown
    check("R1 ctrl", ctrl, 32'h0);
    check("R1 nmi", {31'b0, nmi}, 32'h0);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    tick = 1'b1;
    repeat (300) @(negedge clk);
    check("R1 quiet", {31'b0, nmi}, 32'h0);

    // R2/R5: disabled, any key; count 0x105 = 261 ticks (tick at load edge ignored, R10)
    wr(mk(7'h15, 1, 5));
    k = cyc;
    check("R4 stored", ctrl, mk(7'h15, 1, 5));
    push(EV_NMI, k + 261);
    push(EV_RST, k + 261 + GRACE);
    drain("R5 first run");
    repeat (2) @(negedge clk);
    check("R8 nmi held", {31'b0, nmi}, 32'h1);
    check("R8 pulse ended", {31'b0, rst_req}, 32'h0);
    repeat (300) @(negedge clk);

    // R3: same key while armed is rejected
    wr(mk(7'h15, 1, 2));
    check("R3 ctrl kept", ctrl, mk(7'h15, 1, 5));
    check("R3 nmi kept", {31'b0, nmi}, 32'h1);
    repeat (300) @(negedge clk);

    // R9/R5: inverted key accepted, count 0 -> with bit8 gives 256
    wr(mk(7'h6a, 1, 0));
    k = cyc;
    check("R9 nmi cleared", {31'b0, nmi}, 32'h0);
    check("R4 stored 2", ctrl, mk(7'h6a, 1, 0));
    push(EV_NMI, k + 256);
    wait_cyc(k + 256);
    tick = 1'b0;             // hold grace
    repeat (5) @(negedge clk);
    check("R7 nmi up", {31'b0, nmi}, 32'h1);
    wr(mk(7'h15, 1, 3));     // refresh during grace
    k = cyc;
    tick = 1'b1;
    check("R9 refresh clears", {31'b0, nmi}, 32'h0);
    push(EV_NMI, k + 259);   // first stage again, not reset
    push(EV_RST, k + 259 + GRACE);
    drain("R9 restart");
    repeat (2) @(negedge clk);

    // R6: stop command
    wr(mk(7'h6a, 0, 5));
    check("R6 ctrl", ctrl, mk(7'h6a, 0, 5));
    check("R9 nmi after stop", {31'b0, nmi}, 32'h0);
    repeat (400) @(negedge clk);
    check("R6 quiet", {31'b0, nmi}, 32'h0);
    // R2: disarmed, arbitrary key
    wr(mk(7'h00, 0, 9));
    check("R2 any key", ctrl, mk(7'h00, 0, 9));

    // R10: ticks gated off for 50 cycles
    tick = 1'b0;
    wr(mk(7'h33, 1, 1));
    k = cyc;
    repeat (50) @(negedge clk);
    tick = 1'b1;
    push(EV_NMI, k + 50 + 257);
    push(EV_RST, k + 50 + 257 + GRACE);
    drain("R10 gated");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule